// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the two pending-interrupt flags of one 8-bit timer/counter and turns them into interrupt requests. The counter logic sends it single-cycle pulses: a compare-match hit, a wrap past the top count, and a turnaround at the bottom count. The turnaround pulse only occurs in phase-correct PWM operation. A mode input picks which pulse counts as an overflow. In normal counting a wrap raises the overflow flag. In phase-correct PWM mode only the turnaround at zero raises it.

Software reaches the block through one write port. The port either clears flags or loads an enable mask. A flag is cleared by writing a one to its bit. It is also cleared by the acknowledge strobe that the interrupt controller sends when it takes that source's vector. Each request line is high while the global enable, the source's mask bit and the source's flag are all one.

Each flag is a small state machine with two states. `FLG_IDLE` means no event is pending. `FLG_PENDING` means an event is waiting. The transitions are as follows:
- SET moves the flag from `FLG_IDLE` to `FLG_PENDING` on a set event.
- CLEAR moves it from `FLG_PENDING` to `FLG_IDLE` on a clear with no set in the same cycle.
- RESET_SET keeps it in `FLG_PENDING` when a set and a clear arrive together.
- HOLD leaves it unchanged in every other case.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset both flags, both mask bits and both request lines are 0.
- R2: A pulse on `evt_match` sets the compare flag (bit 1 of `flag_rd`), visible on the cycle after the pulse.
- R3: With `pwm_mode`=0, a pulse on `evt_wrap` sets the overflow flag (bit 0 of `flag_rd`), and `evt_bottom` has no effect on it.
- R4: With `pwm_mode`=1, a pulse on `evt_bottom` sets the overflow flag, and `evt_wrap` has no effect on it.
- R5: A write with `wr_sel`=0 clears each flag whose bit in `wr_data` is 1. Flags whose bit is 0 keep their value.
- R6: `ack_ovf` clears only the overflow flag, and `ack_cmp` clears only the compare flag.
- R7: When a set event and a clear (by write or by acknowledge) reach the same flag in one cycle, the flag ends up set.
- R8: `irq_ovf` equals `gie & mask[0] & flag[0]` and `irq_cmp` equals `gie & mask[1] & flag[1]`, combinationally from the registered bits.
- R9: A write with `wr_sel`=1 loads `wr_data[1:0]` into the mask, which reads back on `mask_rd[1:0]` on the next cycle. Bits 7..2 of `flag_rd` and `mask_rd` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_mode | input | 1 | 1 = phase-correct PWM, 0 = normal counting |
| evt_wrap | input | 1 | Counter wrapped past top (pulse) |
| evt_match | input | 1 | Counter equals compare value (pulse) |
| evt_bottom | input | 1 | Counter turned around at 0x00 (pulse) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = flag register, 1 = mask register |
| wr_data | input | 8 | Write data |
| gie | input | 1 | Global interrupt enable |
| ack_ovf | input | 1 | Overflow vector taken (pulse) |
| ack_cmp | input | 1 | Compare vector taken (pulse) |
| flag_rd | output | 8 | Flag register read value |
| mask_rd | output | 8 | Mask register read value |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |

## Verification
A set event and a clear can reach the same flag in the same cycle. The clear can come from a flag write or from a vector acknowledge. The bench provokes both cases. It pulses `evt_match` together with `ack_cmp`. It also pulses `evt_bottom` in PWM mode together with a write of ones to both flags. It then reads `flag_rd` on the following cycle and expects the flag that was set to stay 1, while a flag that was only cleared in that cycle drops to 0.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int NUM_SRC = 2;
    localparam int IDX_OVF = 0;
    localparam int IDX_CMP = 1;
    localparam logic SEL_FLAG = 1'b0;
    localparam logic SEL_MASK = 1'b1;

    typedef enum logic {
        FLG_IDLE    = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_e;
endpackage

// File: rtl/tmr_irq_ovf_src.sv
module tmr_irq_ovf_src (
    input  logic pwm_mode,
    input  logic evt_wrap,
    input  logic evt_bottom,
    output logic ovf_set
);
    always_comb begin
        if (pwm_mode) ovf_set = evt_bottom;
        else          ovf_set = evt_wrap;
    end
endmodule

// File: rtl/tmr_irq_flag_cell.sv
module tmr_irq_flag_cell
    import tmr_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (set_i) state_d = FLG_PENDING;
            end
            FLG_PENDING: begin
                if (clr_i && !set_i) state_d = FLG_IDLE;
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == FLG_PENDING);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o); // R7
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o); // R5
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(pend_o)); // R6
endmodule

// File: rtl/tmr_irq_mask_reg.sv
module tmr_irq_mask_reg #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wd,
    output logic [WIDTH-1:0] mask_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)  mask_o <= '0;
        else if (we) mask_o <= wd;
    end

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mask_o == $past(wd))); // R9
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tmr_irq_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_mode,
    input  logic             evt_wrap,
    input  logic             evt_match,
    input  logic             evt_bottom,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             gie,
    input  logic             ack_ovf,
    input  logic             ack_cmp,
    output logic [REG_W-1:0] flag_rd,
    output logic [REG_W-1:0] mask_rd,
    output logic             irq_ovf,
    output logic             irq_cmp
);
    localparam int PAD_W = REG_W - NUM_SRC;

    logic               ovf_set;
    logic [NUM_SRC-1:0] set_vec, ack_vec, clr_vec, pend_vec, mask_vec, irq_vec;
    logic               wr_flag, wr_mask;
    logic               unused_wr_hi;

    assign wr_flag      = wr_en && (wr_sel == SEL_FLAG);
    assign wr_mask      = wr_en && (wr_sel == SEL_MASK);
    assign unused_wr_hi = ^wr_data[REG_W-1:NUM_SRC];

    tmr_irq_ovf_src u_ovf_src (
        .pwm_mode   (pwm_mode),
        .evt_wrap   (evt_wrap),
        .evt_bottom (evt_bottom),
        .ovf_set    (ovf_set)
    );

    always_comb begin
        set_vec          = '0;
        ack_vec          = '0;
        set_vec[IDX_OVF] = ovf_set;
        set_vec[IDX_CMP] = evt_match;
        ack_vec[IDX_OVF] = ack_ovf;
        ack_vec[IDX_CMP] = ack_cmp;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign clr_vec[i] = ack_vec[i] | (wr_flag & wr_data[i]);

        tmr_irq_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (clr_vec[i]),
            .pend_o (pend_vec[i])
        );

        assign irq_vec[i] = gie & mask_vec[i] & pend_vec[i];
    end

    tmr_irq_mask_reg #(.WIDTH(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_mask),
        .wd     (wr_data[NUM_SRC-1:0]),
        .mask_o (mask_vec)
    );

    assign flag_rd = {{PAD_W{1'b0}}, pend_vec};
    assign mask_rd = {{PAD_W{1'b0}}, mask_vec};
    assign irq_ovf = irq_vec[IDX_OVF];
    assign irq_cmp = irq_vec[IDX_CMP];

    AST_PWM_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && evt_wrap && !evt_bottom && !flag_rd[IDX_OVF]) |=> !flag_rd[IDX_OVF]); // R4
    AST_NORMAL_NO_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode && evt_bottom && !evt_wrap && !flag_rd[IDX_OVF]) |=> !flag_rd[IDX_OVF]); // R3
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_match |=> flag_rd[IDX_CMP]); // R2
    AST_IRQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cmp || irq_ovf) |-> gie); // R8
    AST_IRQ_CMP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmp |-> (flag_rd[IDX_CMP] && mask_rd[IDX_CMP])); // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd[REG_W-1:NUM_SRC] == '0) && (mask_rd[REG_W-1:NUM_SRC] == '0)); // R9
endmodule

// File: tb/tmr_irq_flags_bench.sv
module tmr_irq_flags_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_mode = 0, evt_wrap = 0, evt_match = 0, evt_bottom = 0;
    logic       wr_en = 0, wr_sel = 0, gie = 0, ack_ovf = 0, ack_cmp = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] flag_rd, mask_rd;
    logic       irq_ovf, irq_cmp;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tmr_irq_flags u_tmr_irq_flags (
        .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .evt_wrap(evt_wrap),
        .evt_match(evt_match), .evt_bottom(evt_bottom), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .gie(gie), .ack_ovf(ack_ovf),
        .ack_cmp(ack_cmp), .flag_rd(flag_rd), .mask_rd(mask_rd),
        .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
    );

    // vector: pwm,wrap,match,bottom,wr_en,wr_sel,wr_data[7:0],ack_ovf,ack_cmp,gie,
    //         exp_flag[1:0],exp_irq[1:0],req[3:0]
    function automatic logic [24:0] mkv(logic p, logic w, logic m, logic b,
        logic we, logic ws, logic [7:0] wd, logic ao, logic ac, logic g,
        logic [1:0] ef, logic [1:0] ei, logic [3:0] rq);
        return {p, w, m, b, we, ws, wd, ao, ac, g, ef, ei, rq};
    endfunction

    localparam int NV = 15;
    localparam logic [24:0] VEC [NV] = '{
        mkv(0,0,0,0, 1,1,8'h03, 0,0,0, 2'b00,2'b00, 4'd9), // R9 mask load
        mkv(0,0,1,0, 0,0,8'h00, 0,0,1, 2'b10,2'b10, 4'd2), // R2 match
        mkv(0,1,0,0, 0,0,8'h00, 0,0,1, 2'b11,2'b11, 4'd3), // R3 wrap
        mkv(0,0,0,0, 0,0,8'h00, 0,0,0, 2'b11,2'b00, 4'd8), // R8 gie off
        mkv(0,0,0,0, 1,0,8'h00, 0,0,1, 2'b11,2'b11, 4'd5), // R5 write zeros
        mkv(0,0,0,0, 1,0,8'h01, 0,0,1, 2'b10,2'b10, 4'd5), // R5 clear ovf
        mkv(0,0,0,0, 0,0,8'h00, 0,1,1, 2'b00,2'b00, 4'd6), // R6 ack cmp
        mkv(0,0,0,1, 0,0,8'h00, 0,0,1, 2'b00,2'b00, 4'd3), // R3 bottom ignored
        mkv(1,1,0,0, 0,0,8'h00, 0,0,1, 2'b00,2'b00, 4'd4), // R4 wrap ignored
        mkv(1,0,0,1, 0,0,8'h00, 0,0,1, 2'b01,2'b01, 4'd4), // R4 bottom sets
        mkv(0,0,1,0, 0,0,8'h00, 0,1,1, 2'b11,2'b11, 4'd7), // R7 match+ack
        mkv(0,0,0,0, 0,0,8'h00, 1,0,1, 2'b10,2'b10, 4'd6), // R6 ack ovf
        mkv(1,0,0,1, 1,0,8'h03, 0,0,1, 2'b01,2'b01, 4'd7), // R7 bottom+write
        mkv(0,0,0,0, 1,1,8'h02, 0,0,1, 2'b01,2'b00, 4'd8), // R8 mask off ovf
        mkv(0,0,1,0, 0,0,8'h00, 0,0,1, 2'b11,2'b10, 4'd8)  // R8 cmp only
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        pwm_mode = 0; evt_wrap = 0; evt_match = 0; evt_bottom = 0;
        wr_en = 0; wr_sel = 0; wr_data = '0; ack_ovf = 0; ack_cmp = 0;
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 flags", flag_rd, 8'h00);
        check("R1 mask", mask_rd, 8'h00);
        check("R1 irq", {6'b0, irq_cmp, irq_ovf}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {pwm_mode, evt_wrap, evt_match, evt_bottom, wr_en, wr_sel, wr_data,
             ack_ovf, ack_cmp, gie} = VEC[i][24:8];
            @(posedge clk);
            #2;
            check($sformatf("R%0d flags v%0d", VEC[i][3:0], i), flag_rd, {6'b0, VEC[i][7:6]});
            check($sformatf("R%0d irq v%0d", VEC[i][3:0], i), {6'b0, irq_cmp, irq_ovf},
                  {6'b0, VEC[i][5:4]});
        end

        // R9 readback and upper bits
        @(negedge clk);
        idle_inputs();
        check("R9 mask readback", mask_rd, 8'h02);
        wr_en = 1; wr_sel = 1; wr_data = 8'hFF;
        @(negedge clk);
        idle_inputs();
        check("R9 mask upper zero", mask_rd, 8'h03);
        check("R9 flag upper zero", flag_rd, 8'h03);
        // R8 combinational: gie drop affects irq without a clock edge
        gie = 0;
        #1;
        check("R8 gie comb", {6'b0, irq_cmp, irq_ovf}, 8'h00);
        gie = 1;
        #1;
        check("R8 gie comb on", {6'b0, irq_cmp, irq_ovf}, 8'h03);

        // R1 reset mid-run
        rst_n = 0;
        @(negedge clk);
        check("R1 flags after reset", flag_rd, 8'h00);
        check("R1 mask after reset", mask_rd, 8'h00);
        rst_n = 1;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule